// File: doc/BRIEF.md
# JPEG Byte Stream Port Packer

This block takes the byte stream leaving a JPEG encoder and presents it on an 8-bit camera-style output port. The encoder side can deliver one byte per clock. The port side advances only on cycles where a slot enable is high, so it is usually slower. A small FIFO sits between the two sides. Bytes leave the FIFO in bursts. During a burst the data-enable line is high. A separate frame line brackets each encoded image.

A burst starts once the FIFO holds a full packet or holds the final byte of a frame. Every burst except the one that closes a frame is exactly one packet long.

In four-byte mode the block appends filler bytes after the end of each frame, so that every frame and every burst is a multiple of four bytes long.

If the encoder overruns the FIFO, the block cuts the frame short. It writes a truncation code as the frame's final byte, raises a sticky error flag and discards input until the next frame start. Reading the status clears the flag. The number of bytes written for the most recent frame is held for the host.

Top module: `jpeg_port_packer`

## Requirements
- R1: After reset, out_hblk, out_vblk and err_flag are low, frame_bytes is zero and the FIFO is empty.
- R2: The output changes only at the end of a cycle with port_ce high. In each such slot, out_hblk is high exactly when out_data carries a byte. Stream bytes leave in the order they were written.
- R3: When no burst is in progress, a burst starts in a slot where the FIFO holds at least PKT entries, or holds an entry flagged as a frame's last byte. A burst lasts PKT bytes unless it reaches the frame's last byte first, in which case it ends there (after any filler).
- R4: out_vblk rises in the slot that carries a byte written with in_sof. It falls in the slot after the frame's final output byte (stream byte or filler). In that slot out_hblk is low.
- R5: With quad_mode high when a frame's last byte leaves, the block appends filler bytes of value 8'hA5 until the frame's output length is a multiple of four. Every out_hblk-high run is then a multiple of four slots.
- R6: With quad_mode low, no filler is appended and the frame's output length equals its written length.
- R7: A byte accepted while the FIFO already holds DEPTH-1 entries (counted before that cycle's read) is an overflow. If exactly DEPTH-1 entries are held, byte 8'hFE is written as the frame's last entry in place of that byte. err_flag is set. The FIFO never holds more than DEPTH entries.
- R8: After an overflow, input bytes are discarded until a byte with in_sof arrives, and that byte is accepted.
- R9: err_flag stays high until the cycle after stat_rd is high. An overflow in the same cycle as stat_rd keeps it high.
- R10: frame_bytes is loaded when a frame's last entry is written. It holds the number of entries written for that frame, with the in_sof byte counted as 1 and the truncation byte included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Encoder byte present |
| in_data | input | 8 | Encoder byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| quad_mode | input | 1 | Pad frames to a multiple of four bytes |
| port_ce | input | 1 | Output slot enable |
| stat_rd | input | 1 | Host status read strobe, clears err_flag |
| out_data | output | 8 | Port data byte |
| out_hblk | output | 1 | Port data enable |
| out_vblk | output | 1 | Frame active |
| err_flag | output | 1 | Sticky overflow flag |
| frame_bytes | output | CNT_W | Entry count of the last completed frame |

## Verification
The bench builds the block with DEPTH=16 and PKT=8. With these values, a short frame fed at full rate into a port enabled one slot in four overruns the FIFO within a few dozen cycles. Partial packets that must wait for more data, and frames that end mid-packet, also appear in frames of only ten to sixty bytes. Varying the port enable ratio and the input gap moves the FIFO between nearly empty and nearly full. Frame lengths of every residue modulo four exercise each filler count.

// File: rtl/jpeg_port_packer.sv
module jpeg_port_packer #(
  parameter int DEPTH = 64,
  parameter int PKT   = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             quad_mode,
  input  logic             port_ce,
  input  logic             stat_rd,
  output logic [7:0]       out_data,
  output logic             out_hblk,
  output logic             out_vblk,
  output logic             err_flag,
  output logic [CNT_W-1:0] frame_bytes
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(PKT + 1);
  localparam logic [7:0] FILL  = 8'hA5;
  localparam logic [7:0] TRUNC = 8'hFE;

  logic [9:0]       mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, lastcnt;
  logic             drop, busy, gap;
  logic [BW-1:0]    bl;
  logic [1:0]       pad_rem, fmod;
  logic [CNT_W-1:0] run;

  wire             take      = in_valid && (!drop || in_sof);
  wire             near_full = cnt >= CW'(DEPTH - 1);
  wire             ovf       = take && near_full;
  wire             wr        = take && (!near_full || cnt == CW'(DEPTH - 1));
  wire [9:0]       wr_ent    = near_full ? {in_sof, 1'b1, TRUNC} : {in_sof, in_eof, in_data};
  wire [CNT_W-1:0] run_n     = in_sof ? CNT_W'(1) : run + CNT_W'(1);

  wire [9:0]    head    = mem[rp];
  wire          start   = (cnt >= CW'(PKT)) || (lastcnt != '0);
  wire          padding = busy && (pad_rem != 2'd0);
  wire          rd      = port_ce && !gap && !padding && (busy || start);
  wire [1:0]    fmod_n  = (head[9] ? 2'd0 : fmod) + 2'd1;
  wire [1:0]    pad_n   = quad_mode ? 2'd0 - fmod_n : 2'd0;
  wire [BW-1:0] bl_n    = (busy ? bl : '0) + BW'(1);

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      lastcnt <= '0;
    end else begin
      if (wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(wr) - CW'(rd);
      lastcnt <= lastcnt + CW'(wr && wr_ent[8]) - CW'(rd && head[8]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      drop <= 1'b0;
      run <= '0;
      frame_bytes <= '0;
    end else begin
      err_flag <= ovf || (err_flag && !stat_rd);
      if (ovf) drop <= 1'b1;
      else if (take && in_sof) drop <= 1'b0;
      if (wr) begin
        run <= run_n;
        if (wr_ent[8]) frame_bytes <= run_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_hblk <= 1'b0;
      out_vblk <= 1'b0;
      busy <= 1'b0;
      gap <= 1'b0;
      bl <= '0;
      pad_rem <= '0;
      fmod <= '0;
    end else if (port_ce) begin
      if (gap) begin
        out_hblk <= 1'b0;
        out_vblk <= 1'b0;
        gap <= 1'b0;
      end else if (padding) begin
        out_data <= FILL;
        out_hblk <= 1'b1;
        pad_rem <= pad_rem - 2'd1;
        if (pad_rem == 2'd1) begin
          busy <= 1'b0;
          gap <= 1'b1;
        end
      end else if (rd) begin
        out_data <= head[7:0];
        out_hblk <= 1'b1;
        fmod <= fmod_n;
        if (head[9]) out_vblk <= 1'b1;
        if (head[8]) begin
          if (pad_n == 2'd0) begin
            busy <= 1'b0;
            gap <= 1'b1;
          end else begin
            busy <= 1'b1;
            pad_rem <= pad_n;
          end
        end else if (bl_n == BW'(PKT)) begin
          busy <= 1'b0;
        end else begin
          busy <= 1'b1;
          bl <= bl_n;
        end
      end else begin
        out_hblk <= 1'b0;
      end
    end
  end

  logic [1:0] hrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hrun <= '0;
    else if (port_ce) hrun <= out_hblk ? hrun + 2'd1 : 2'd0;
  end

  assert_quad_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ce && !out_hblk && quad_mode) |-> (hrun == 2'd0));
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (cnt != '0));
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(stat_rd));
  assert_vblk_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vblk) |-> !out_hblk);
endmodule

// File: tb/jpeg_port_packer_tb.sv
module jpeg_port_packer_tb_top;
  localparam int DEPTH = 16;
  localparam int PKT   = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, quad_mode = 0, port_ce = 0, stat_rd = 0;
  logic [7:0] in_data = 0;
  logic [7:0] out_data;
  logic out_hblk, out_vblk, err_flag;
  logic [23:0] frame_bytes;

  jpeg_port_packer #(.DEPTH(DEPTH), .PKT(PKT), .CNT_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .quad_mode(quad_mode), .port_ce(port_ce),
    .stat_rd(stat_rd), .out_data(out_data), .out_hblk(out_hblk),
    .out_vblk(out_vblk), .err_flag(err_flag), .frame_bytes(frame_bytes));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Port enable generator
  int ce_div = 1;
  int ph = 0;
  initial forever begin
    @(negedge clk);
    ph++;
    port_ce = (ph % ce_div) == 0;
  end

  // Reference model
  int q[$];
  int m_lastcnt, m_bl, m_pad, m_mod, m_run;
  bit m_busy, m_gap, m_drop, m_hblk, m_vblk, m_err;
  int m_data, m_fbytes;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_lastcnt = 0; m_bl = 0; m_pad = 0; m_mod = 0; m_run = 0;
      m_busy = 0; m_gap = 0; m_drop = 0; m_hblk = 0; m_vblk = 0; m_err = 0;
      m_data = 0; m_fbytes = 0;
    end else begin
      int cnt0, lc0, e, pd;
      bit take, setov;
      cnt0 = q.size();
      lc0 = m_lastcnt;
      if (port_ce) begin
        if (m_gap) begin
          m_hblk = 0; m_vblk = 0; m_gap = 0;
        end else if (m_busy && m_pad > 0) begin
          m_data = 8'hA5; m_hblk = 1; m_pad--;
          if (m_pad == 0) begin m_busy = 0; m_gap = 1; end
        end else if (m_busy || cnt0 >= PKT || lc0 > 0) begin
          e = q.pop_front();
          m_data = e & 8'hFF; m_hblk = 1;
          if (e[9]) begin m_vblk = 1; m_mod = 0; end
          m_mod = (m_mod + 1) % 4;
          m_bl = (m_busy ? m_bl : 0) + 1;
          if (e[8]) begin
            m_lastcnt--;
            pd = quad_mode ? (4 - m_mod) % 4 : 0;
            if (pd == 0) begin m_busy = 0; m_gap = 1; end
            else begin m_busy = 1; m_pad = pd; end
          end else if (m_bl == PKT) m_busy = 0;
          else m_busy = 1;
        end else m_hblk = 0;
      end
      take = in_valid && (!m_drop || in_sof);
      setov = 0;
      if (take) begin
        if (cnt0 >= DEPTH - 1) begin
          setov = 1; m_drop = 1;
          if (cnt0 == DEPTH - 1) begin
            q.push_back((int'(in_sof) << 9) | (1 << 8) | 8'hFE);
            m_lastcnt++;
            m_run = in_sof ? 1 : m_run + 1;
            m_fbytes = m_run;
          end
        end else begin
          q.push_back((int'(in_sof) << 9) | (int'(in_eof) << 8) | in_data);
          if (in_eof) m_lastcnt++;
          m_run = in_sof ? 1 : m_run + 1;
          if (in_eof) m_fbytes = m_run;
          if (in_sof) m_drop = 0;
        end
      end
      m_err = setov ? 1 : (stat_rd ? 0 : m_err);
    end
  end

  // Output monitor
  bit ce_q;
  int seen = 0, a5_seen = 0, last_byte = 0;
  always @(posedge clk) ce_q <= port_ce;
  always @(negedge clk) if (rst_n && ce_q && out_hblk) begin
    seen++;
    if (out_data == 8'hA5) a5_seen++;
    last_byte = out_data;
  end

  // Every-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    compared++;
    if (out_hblk !== m_hblk || (m_hblk && out_data !== 8'(m_data)) ||
        out_vblk !== m_vblk || err_flag !== m_err || frame_bytes !== 24'(m_fbytes)) begin
      mismatched++;
      if (out_hblk !== m_hblk) $display("FAIL R2 hblk actual=%0h expected=%0h", out_hblk, m_hblk);
      if (m_hblk && out_data !== 8'(m_data)) $display("FAIL R2 data actual=%0h expected=%0h", out_data, m_data);
      if (out_vblk !== m_vblk) $display("FAIL R4 vblk actual=%0h expected=%0h", out_vblk, m_vblk);
      if (err_flag !== m_err) $display("FAIL R9 err actual=%0h expected=%0h", err_flag, m_err);
      if (frame_bytes !== 24'(m_fbytes)) $display("FAIL R10 count actual=%0h expected=%0h", frame_bytes, m_fbytes);
    end
  end

  task automatic put(input logic [7:0] d, input bit s, input bit e, input int ig);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sof = s; in_eof = e;
    repeat (ig) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  task automatic idle_in(int n);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] fbyte(int i, int n);
    if (i == 0 || i == n - 2) return 8'hFF;
    if (i == 1) return 8'hD8;
    if (i == n - 1) return 8'hD9;
    return 8'((i * 7) & 8'h7F);
  endfunction

  task automatic frame(int n, int ig);
    for (int i = 0; i < n; i++) put(fbyte(i, n), i == 0, i == n - 1, ig);
    idle_in(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_hblk == 0 && out_vblk == 0, "R1 outputs", {out_hblk, out_vblk}, 0);
    chk(err_flag == 0 && frame_bytes == 0, "R1 status", frame_bytes, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R6 / R10: plain frame, odd length, no filler
    ce_div = 1; quad_mode = 0; seen = 0; a5_seen = 0;
    frame(21, 1);
    idle_in(40);
    chk(seen == 21, "R6 length", seen, 21);
    chk(a5_seen == 0, "R6 filler", a5_seen, 0);
    chk(frame_bytes == 21, "R10 count", frame_bytes, 21);

    // R3: partial packet waits, full packet goes
    seen = 0;
    for (int i = 0; i < 5; i++) put(fbyte(i, 14), i == 0, 0, 1);
    idle_in(20);
    chk(seen == 0, "R3 hold", seen, 0);
    for (int i = 5; i < 8; i++) put(fbyte(i, 14), 0, 0, 1);
    idle_in(20);
    chk(seen == PKT, "R3 packet", seen, PKT);
    for (int i = 8; i < 14; i++) put(fbyte(i, 14), 0, i == 13, 1);
    idle_in(20);
    chk(seen == 14, "R3 tail", seen, 14);
    chk(last_byte == 8'hD9, "R2 order", last_byte, 8'hD9);

    // R5: four-byte mode, each residue
    ce_div = 2; quad_mode = 1;
    for (int n = 20; n < 24; n++) begin
      seen = 0; a5_seen = 0;
      frame(n, 1);
      idle_in(80);
      chk(seen == ((n + 3) / 4) * 4, "R5 length", seen, ((n + 3) / 4) * 4);
      chk(a5_seen == ((n + 3) / 4) * 4 - n, "R5 filler", a5_seen, ((n + 3) / 4) * 4 - n);
    end
    quad_mode = 0;
    idle_in(10);

    // R7: overflow truncates the frame
    ce_div = 4; seen = 0;
    frame(60, 0);
    chk(err_flag == 1, "R7 flag", err_flag, 1);
    idle_in(200);
    chk(last_byte == 8'hFE, "R7 trunc code", last_byte, 8'hFE);

    // R8: bytes without frame start are dropped
    seen = 0; ce_div = 1;
    for (int i = 0; i < 12; i++) put(8'h30 + 8'(i), 0, i == 11, 0);
    idle_in(40);
    chk(seen == 0, "R8 drop", seen, 0);
    frame(12, 1);
    idle_in(40);
    chk(seen == 12, "R8 resume", seen, 12);
    chk(frame_bytes == 12, "R10 restart", frame_bytes, 12);
    chk(err_flag == 1, "R9 sticky", err_flag, 1);

    // R9: read clears
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk(err_flag == 0, "R9 clear", err_flag, 0);
    idle_in(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    done = 1;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule